// File: doc/BRIEF.md
# USB FIFO Endpoint Transfer Controller

This block moves 32-bit words between two host-side FIFOs and the slave-FIFO port of an external high-speed USB device. A processor programs it through a small register bus. A control register holds the transmit and receive FIFO resets, the outbound endpoint choice and a receive byte-alignment option. A second register holds the idle timeout for short packets.

The controller has two phases. In the outbound phase it drains the transmit FIFO into the selected endpoint, one word per cycle. When the device reports inbound data on the dedicated receive endpoint, the controller switches to that endpoint and fills the receive FIFO. It goes back to the outbound endpoint once the device reports the inbound endpoint as empty.

The device sends a packet on its own once 512 bytes are buffered. A packet shorter than that stays in the device until something closes it. An idle timer does this. It counts outbound cycles in which the transmit FIFO is empty and the endpoint buffer holds an unsent partial packet. When the count reaches the programmed value, the timer pulses the packet-end strobe.

Top module: `usb_ep_xfer_ctrl`

## Requirements
- R1: After reset the control and timeout registers read 0, both FIFO resets are low, `usb_addr` is 2'b00 and no strobe is active.
- R2: The control register is at address 0. Bit 0 drives `tx_fifo_rst` and bit 1 drives `rx_fifo_rst`. Each bit holds its value until software writes it again, and the register reads back what was written.
- R3: Control bits [5:4] select the outbound endpoint and `usb_addr`: 0 gives 2'b00, 1 gives 2'b01, 2 gives 2'b10, and 3 gives 2'b00. Writing 0x10 therefore gives 2'b01. The inbound endpoint uses `usb_addr` 2'b11.
- R4: In the outbound phase a word is transferred in the same cycle, with `tx_rd` and `usb_wr` high and `usb_wdata` equal to `tx_data`, whenever `tx_empty`, `usb_full` and `tx_fifo_rst` are all low.
- R5: In the outbound phase, when `usb_in_avail` is high, no word is transmitted in that cycle and `usb_addr` is 2'b11 from the next cycle. In the inbound phase a word is moved, with `usb_rd` and `rx_wr` high, whenever `usb_in_avail` is high and `rx_full` and `rx_fifo_rst` are low.
- R6: In the inbound phase, when `usb_in_avail` is low, the next cycle returns to the outbound phase with `usb_addr` set by R3.
- R7: The timeout register is at address 1 and holds a value T. If T is greater than 0 and the endpoint holds a partial packet, then after T consecutive outbound cycles with `tx_empty` high, `usb_pktend` is high for exactly one cycle. That cycle is the (T+1)-th cycle after the last write. No word is written while `usb_pktend` is high.
- R8: Every word written to the endpoint restarts the idle count.
- R9: Entering the inbound phase clears the idle count, so a full run of T idle outbound cycles is needed after the return.
- R10: A timeout of 0 disables packet-end generation.
- R11: A run of 128 words (512 bytes) counts as a full packet that the device sends by itself. After such a run no packet end is generated until another word is written.
- R12: When control bit 8 is 1, `rx_wdata` equals `usb_rdata` rotated right by 8 bits. When bit 8 is 0, `rx_wdata` equals `usb_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 = control, 1 = timeout) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_fifo_rst | output | 1 | Reset to the transmit FIFO |
| rx_fifo_rst | output | 1 | Reset to the receive FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word (first-word fall-through) |
| tx_rd | output | 1 | Transmit FIFO pop |
| rx_full | input | 1 | Receive FIFO full |
| rx_wr | output | 1 | Receive FIFO push |
| rx_wdata | output | 32 | Receive FIFO write data |
| usb_addr | output | 2 | Device endpoint FIFO address |
| usb_full | input | 1 | Addressed endpoint full |
| usb_in_avail | input | 1 | Inbound endpoint holds data |
| usb_wr | output | 1 | Device write strobe |
| usb_wdata | output | 32 | Device write data |
| usb_rd | output | 1 | Device read strobe |
| usb_rdata | input | 32 | Device read data |
| usb_pktend | output | 1 | Packet-end strobe |

## Verification
A wrong phase register shows up within one cycle. `usb_addr` presents the wrong endpoint, and the read and write strobes appear where the other direction is expected. A wrong idle or packet word count cannot be seen until the idle run ends. It then shows as a packet-end pulse that comes early, comes late, repeats or never comes. For that reason the tests count the exact cycle of the pulse after a restart, after a trip through the inbound phase and after a full 128-word packet.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

   typedef enum logic [1:0] {
      ADDR_EP2 = 2'b00,
      ADDR_EP4 = 2'b01,
      ADDR_EP6 = 2'b10,
      ADDR_EP8 = 2'b11
   } ep_addr_e;

   typedef enum logic {
      PH_OUT = 1'b0,
      PH_IN  = 1'b1
   } phase_e;

   localparam int CTL_TXRST_BIT = 0;
   localparam int CTL_RXRST_BIT = 1;
   localparam int CTL_EP_LSB    = 4;
   localparam int CTL_SHIFT_BIT = 8;

   typedef struct packed {
      logic       shift_comp;
      logic [1:0] ep_sel;
      logic       rx_rst;
      logic       tx_rst;
   } ctl_t;

   function automatic ep_addr_e ep_decode(input logic [1:0] sel);
      case (sel)
         2'd1:    return ADDR_EP4;
         2'd2:    return ADDR_EP6;
         default: return ADDR_EP2;
      endcase
   endfunction

endpackage

// File: rtl/usb_ep_ctl_regs.sv
module usb_ep_ctl_regs
   import usb_ep_pkg::*;
#(
   parameter int REG_AW        = 2,
   parameter int REG_DW        = 32,
   parameter int TMO_W         = 16,
   parameter bit SHIFT_COMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output ctl_t              ctl,
   output logic [TMO_W-1:0]  tmo
);
   localparam logic [REG_AW-1:0] A_CTL = REG_AW'(0);
   localparam logic [REG_AW-1:0] A_TMO = REG_AW'(1);

   ctl_t             ctl_q;
   logic [TMO_W-1:0] tmo_q;
   logic             shift_wr;

   generate
      if (SHIFT_COMP_EN) begin : g_shift
         assign shift_wr = reg_wdata[CTL_SHIFT_BIT];
      end else begin : g_noshift
         assign shift_wr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         tmo_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == A_CTL) begin
            ctl_q.tx_rst     <= reg_wdata[CTL_TXRST_BIT];
            ctl_q.rx_rst     <= reg_wdata[CTL_RXRST_BIT];
            ctl_q.ep_sel     <= reg_wdata[CTL_EP_LSB +: 2];
            ctl_q.shift_comp <= shift_wr;
         end else if (reg_addr == A_TMO) begin
            tmo_q <= reg_wdata[TMO_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTL) begin
         reg_rdata[CTL_TXRST_BIT]      = ctl_q.tx_rst;
         reg_rdata[CTL_RXRST_BIT]      = ctl_q.rx_rst;
         reg_rdata[CTL_EP_LSB +: 2]    = ctl_q.ep_sel;
         reg_rdata[CTL_SHIFT_BIT]      = ctl_q.shift_comp;
      end else if (reg_addr == A_TMO) begin
         reg_rdata[TMO_W-1:0] = tmo_q;
      end
   end

   assign ctl = ctl_q;
   assign tmo = tmo_q;

endmodule

// File: rtl/usb_ep_arbiter.sv
module usb_ep_arbiter
   import usb_ep_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter bit SHIFT_COMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic              pktend_busy,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_rd,
   input  logic              rx_full,
   output logic              rx_wr,
   output logic [DATA_W-1:0] rx_wdata,
   output logic [1:0]        usb_addr,
   input  logic              usb_full,
   input  logic              usb_in_avail,
   output logic              usb_wr,
   output logic [DATA_W-1:0] usb_wdata,
   output logic              usb_rd,
   input  logic [DATA_W-1:0] usb_rdata,
   output logic              out_phase
);
   phase_e phase_q, phase_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_OUT;
      else        phase_q <= phase_nxt;
   end

   always_comb begin
      phase_nxt = phase_q;
      tx_rd     = 1'b0;
      usb_wr    = 1'b0;
      usb_rd    = 1'b0;
      rx_wr     = 1'b0;
      case (phase_q)
         PH_OUT: begin
            if (pktend_busy) begin
               phase_nxt = PH_OUT;
            end else if (usb_in_avail) begin
               phase_nxt = PH_IN;
            end else if (!tx_empty && !usb_full && !ctl.tx_rst) begin
               tx_rd  = 1'b1;
               usb_wr = 1'b1;
            end
         end
         default: begin
            if (!usb_in_avail) begin
               phase_nxt = PH_OUT;
            end else if (!rx_full && !ctl.rx_rst) begin
               usb_rd = 1'b1;
               rx_wr  = 1'b1;
            end
         end
      endcase
   end

   assign usb_addr  = (phase_q == PH_IN) ? ADDR_EP8 : ep_decode(ctl.ep_sel);
   assign usb_wdata = tx_data;
   assign out_phase = (phase_q == PH_OUT);

   generate
      if (SHIFT_COMP_EN) begin : g_rot
         assign rx_wdata = ctl.shift_comp ? {usb_rdata[7:0], usb_rdata[DATA_W-1:8]}
                                          : usb_rdata;
      end else begin : g_pass
         assign rx_wdata = usb_rdata;
      end
   endgenerate

endmodule

// File: rtl/usb_ep_pktend_timer.sv
module usb_ep_pktend_timer #(
   parameter int TMO_W     = 16,
   parameter int PKT_WORDS = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMO_W-1:0] tmo,
   input  logic             out_phase,
   input  logic             word_wr,
   input  logic             tx_empty,
   output logic             pktend
);
   localparam int PCW = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
   localparam logic [PCW-1:0]   PKT_LAST = PCW'(PKT_WORDS - 1);
   localparam logic [TMO_W-1:0] ONE      = TMO_W'(1);

   logic [PCW-1:0]   pkt_cnt_q;
   logic [TMO_W-1:0] idle_q;
   logic             pend_q;
   logic             partial;
   logic             armed;
   logic             fire;

   assign partial = (pkt_cnt_q != '0);
   assign armed   = out_phase && tx_empty && partial && (tmo != '0) && !pend_q;
   assign fire    = armed && (idle_q == tmo - ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= '0;
      end else if (!armed || word_wr || fire) begin
         idle_q <= '0;
      end else begin
         idle_q <= idle_q + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_cnt_q <= '0;
      end else if (fire) begin
         pkt_cnt_q <= '0;
      end else if (word_wr) begin
         pkt_cnt_q <= (pkt_cnt_q == PKT_LAST) ? '0 : pkt_cnt_q + PCW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= fire;
   end

   assign pktend = pend_q;

endmodule

// File: rtl/usb_ep_xfer_ctrl.sv
module usb_ep_xfer_ctrl
   import usb_ep_pkg::*;
#(
   parameter int REG_AW        = 2,
   parameter int DATA_W        = 32,
   parameter int TMO_W         = 16,
   parameter int PKT_BYTES     = 512,
   parameter bit SHIFT_COMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              tx_fifo_rst,
   output logic              rx_fifo_rst,
   input  logic              tx_empty,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_rd,
   input  logic              rx_full,
   output logic              rx_wr,
   output logic [DATA_W-1:0] rx_wdata,
   output logic [1:0]        usb_addr,
   input  logic              usb_full,
   input  logic              usb_in_avail,
   output logic              usb_wr,
   output logic [DATA_W-1:0] usb_wdata,
   output logic              usb_rd,
   input  logic [DATA_W-1:0] usb_rdata,
   output logic              usb_pktend
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int PKT_WORDS  = PKT_BYTES / WORD_BYTES;

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_dw
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tw
         $error("TMO_W must lie in 1..32");
      end
      if (REG_AW < 1) begin : g_bad_aw
         $error("REG_AW must be at least 1");
      end
      if (PKT_WORDS < 2 || (PKT_BYTES % WORD_BYTES) != 0) begin : g_bad_pk
         $error("PKT_BYTES must hold a whole number of at least two words");
      end
   endgenerate

   ctl_t             ctl_q;
   logic [TMO_W-1:0] tmo_q;
   logic             out_phase;
   logic             pktend_q;

   usb_ep_ctl_regs #(
      .REG_AW        (REG_AW),
      .REG_DW        (32),
      .TMO_W         (TMO_W),
      .SHIFT_COMP_EN (SHIFT_COMP_EN)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ctl       (ctl_q),
      .tmo       (tmo_q)
   );

   usb_ep_arbiter #(
      .DATA_W        (DATA_W),
      .SHIFT_COMP_EN (SHIFT_COMP_EN)
   ) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl          (ctl_q),
      .pktend_busy  (pktend_q),
      .tx_empty     (tx_empty),
      .tx_data      (tx_data),
      .tx_rd        (tx_rd),
      .rx_full      (rx_full),
      .rx_wr        (rx_wr),
      .rx_wdata     (rx_wdata),
      .usb_addr     (usb_addr),
      .usb_full     (usb_full),
      .usb_in_avail (usb_in_avail),
      .usb_wr       (usb_wr),
      .usb_wdata    (usb_wdata),
      .usb_rd       (usb_rd),
      .usb_rdata    (usb_rdata),
      .out_phase    (out_phase)
   );

   usb_ep_pktend_timer #(
      .TMO_W     (TMO_W),
      .PKT_WORDS (PKT_WORDS)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .tmo       (tmo_q),
      .out_phase (out_phase),
      .word_wr   (usb_wr),
      .tx_empty  (tx_empty),
      .pktend    (pktend_q)
   );

   assign tx_fifo_rst = ctl_q.tx_rst;
   assign rx_fifo_rst = ctl_q.rx_rst;
   assign usb_pktend  = pktend_q;

endmodule

// File: rtl/usb_ep_xfer_chk.sv
module usb_ep_xfer_chk #(
   parameter int TMO_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_empty,
   input logic             tx_fifo_rst,
   input logic             rx_full,
   input logic             rx_wr,
   input logic [1:0]       usb_addr,
   input logic             usb_full,
   input logic             usb_in_avail,
   input logic             usb_wr,
   input logic             usb_rd,
   input logic             usb_pktend,
   input logic [TMO_W-1:0] tmo_val
);
   AST_WR_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      usb_wr |-> (!usb_full && !tx_empty && !tx_fifo_rst)); // R4
   AST_WR_ON_OUT_EP: assert property (@(posedge clk) disable iff (!rst_n)
      usb_wr |-> (usb_addr != 2'b11)); // R4
   AST_RD_ON_IN_EP: assert property (@(posedge clk) disable iff (!rst_n)
      usb_rd |-> (usb_addr == 2'b11)); // R5
   AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr |-> !rx_full); // R5
   AST_SWITCH_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_addr != 2'b11 && usb_in_avail && !usb_pktend) |=> (usb_addr == 2'b11)); // R5
   AST_RETURN_OUTBOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_addr == 2'b11 && !usb_in_avail) |=> (usb_addr != 2'b11)); // R6
   AST_PKTEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      usb_pktend |=> !usb_pktend); // R7
   AST_PKTEND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      usb_pktend |-> !usb_wr); // R7
   AST_ZERO_TMO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_val == '0) |=> !usb_pktend); // R10
endmodule

bind usb_ep_xfer_ctrl usb_ep_xfer_chk #(.TMO_W(TMO_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_empty     (tx_empty),
   .tx_fifo_rst  (tx_fifo_rst),
   .rx_full      (rx_full),
   .rx_wr        (rx_wr),
   .usb_addr     (usb_addr),
   .usb_full     (usb_full),
   .usb_in_avail (usb_in_avail),
   .usb_wr       (usb_wr),
   .usb_rd       (usb_rd),
   .usb_pktend   (usb_pktend),
   .tmo_val      (tmo_q)
);

// File: tb/sim_usb_ep_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_usb_ep_xfer_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_fifo_rst, rx_fifo_rst;
   logic        tx_empty = 1'b1;
   logic [31:0] tx_data = '0;
   logic        tx_rd;
   logic        rx_full = 1'b0;
   logic        rx_wr;
   logic [31:0] rx_wdata;
   logic [1:0]  usb_addr;
   logic        usb_full = 1'b0;
   logic        usb_in_avail = 1'b0;
   logic        usb_wr;
   logic [31:0] usb_wdata;
   logic        usb_rd;
   logic [31:0] usb_rdata = '0;
   logic        usb_pktend;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   usb_ep_xfer_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_fifo_rst(tx_fifo_rst), .rx_fifo_rst(rx_fifo_rst),
      .tx_empty(tx_empty), .tx_data(tx_data), .tx_rd(tx_rd),
      .rx_full(rx_full), .rx_wr(rx_wr), .rx_wdata(rx_wdata),
      .usb_addr(usb_addr), .usb_full(usb_full), .usb_in_avail(usb_in_avail),
      .usb_wr(usb_wr), .usb_wdata(usb_wdata), .usb_rd(usb_rd),
      .usb_rdata(usb_rdata), .usb_pktend(usb_pktend)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 2'd0;
      #1;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // push n words: each cycle tx_empty low, a write must happen
   task automatic send_words(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tx_empty = 1'b0; tx_data = 32'hA000_0000 + i;
         #1;
         if (i == 0 || i == n - 1) check(req, {31'd0, usb_wr}, 32'd1);
      end
      @(negedge clk);
      tx_empty = 1'b1;
   endtask

   // count idle cycles (index 1 = current cycle) until pulse; return first index and pulse count
   task automatic watch_pulse(input int span, output int first, output int pulses);
      first = 0; pulses = 0;
      for (int k = 1; k <= span; k++) begin
         if (k > 1) @(negedge clk);
         #1;
         if (usb_pktend) begin
            pulses++;
            if (first == 0) first = k;
         end
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      step();
      check("R1 usb_addr", {30'd0, usb_addr}, 32'd0);
      check("R1 tx_fifo_rst", {31'd0, tx_fifo_rst}, 32'd0);
      check("R1 rx_fifo_rst", {31'd0, rx_fifo_rst}, 32'd0);
      check("R1 pktend", {31'd0, usb_pktend}, 32'd0);
      reg_read(2'd0, d); check("R1 ctl readback", d, 32'd0);
      reg_read(2'd1, d); check("R1 tmo readback", d, 32'd0);
   endtask

   task automatic t_ctrl;
      logic [31:0] d;
      reg_write(2'd0, 32'h1);
      check("R2 tx_fifo_rst set", {31'd0, tx_fifo_rst}, 32'd1);
      check("R2 rx_fifo_rst clear", {31'd0, rx_fifo_rst}, 32'd0);
      @(negedge clk); tx_empty = 1'b0; #1;
      check("R4 no write in tx reset", {31'd0, usb_wr}, 32'd0);
      @(negedge clk); tx_empty = 1'b1;
      repeat (3) step();
      check("R2 tx_fifo_rst held", {31'd0, tx_fifo_rst}, 32'd1);
      reg_read(2'd0, d); check("R2 readback", d, 32'd1);
      reg_write(2'd0, 32'h0);
      check("R2 tx_fifo_rst released", {31'd0, tx_fifo_rst}, 32'd0);
      reg_write(2'd0, 32'h2);
      check("R2 rx_fifo_rst set", {31'd0, rx_fifo_rst}, 32'd1);
      reg_write(2'd0, 32'h0);
      check("R2 rx_fifo_rst released", {31'd0, rx_fifo_rst}, 32'd0);
   endtask

   task automatic t_ep;
      reg_write(2'd0, 32'h10); check("R3 sel1", {30'd0, usb_addr}, 32'd1);
      reg_write(2'd0, 32'h20); check("R3 sel2", {30'd0, usb_addr}, 32'd2);
      reg_write(2'd0, 32'h30); check("R3 sel3", {30'd0, usb_addr}, 32'd0);
      reg_write(2'd0, 32'h00); check("R3 sel0", {30'd0, usb_addr}, 32'd0);
   endtask

   task automatic t_tx;
      @(negedge clk); tx_empty = 1'b0; tx_data = 32'hCAFE_0001; #1;
      check("R4 usb_wr", {31'd0, usb_wr}, 32'd1);
      check("R4 tx_rd", {31'd0, tx_rd}, 32'd1);
      check("R4 data", usb_wdata, 32'hCAFE_0001);
      @(negedge clk); usb_full = 1'b1; #1;
      check("R4 held on full", {31'd0, usb_wr}, 32'd0);
      @(negedge clk); usb_full = 1'b0; tx_empty = 1'b1; #1;
      check("R4 idle when empty", {31'd0, tx_rd}, 32'd0);
   endtask

   task automatic t_rx;
      reg_write(2'd0, 32'h10);
      @(negedge clk); tx_empty = 1'b0; usb_in_avail = 1'b1; usb_rdata = 32'h1122_3344; #1;
      check("R5 no tx on switch", {31'd0, usb_wr}, 32'd0);
      step();
      check("R5 inbound addr", {30'd0, usb_addr}, 32'd3);
      check("R5 usb_rd", {31'd0, usb_rd}, 32'd1);
      check("R12 pass data", rx_wdata, 32'h1122_3344);
      @(negedge clk); rx_full = 1'b1; #1;
      check("R5 held on rx_full", {31'd0, rx_wr}, 32'd0);
      @(negedge clk); rx_full = 1'b0;
      reg_wdata = 32'h110; reg_we = 1'b1; reg_addr = 2'd0;
      @(negedge clk); reg_we = 1'b0; #1;
      check("R12 rotated data", rx_wdata, 32'h4411_2233);
      @(negedge clk); usb_in_avail = 1'b0; tx_empty = 1'b1; #1;
      check("R6 still inbound", {30'd0, usb_addr}, 32'd3);
      step();
      check("R6 back to outbound", {30'd0, usb_addr}, 32'd1);
      reg_write(2'd0, 32'h10);
      check("R12 flag cleared", rx_wdata, 32'h1122_3344);
   endtask

   task automatic t_pktend;
      int first, pulses;
      reg_write(2'd1, 32'd5);
      send_words(3, "R4 burst");
      watch_pulse(14, first, pulses);
      check("R7 pulse cycle", first, 32'd6);
      check("R7 single pulse", pulses, 32'd1);
   endtask

   task automatic t_restart;
      int first, pulses;
      reg_write(2'd1, 32'd6);
      send_words(1, "R8 first word");
      watch_pulse(4, first, pulses);
      check("R8 no early pulse", pulses, 32'd0);
      send_words(1, "R8 second word");
      watch_pulse(14, first, pulses);
      check("R8 pulse after restart", first, 32'd7);
      check("R8 single pulse", pulses, 32'd1);
   endtask

   task automatic t_inclear;
      int first, pulses, k;
      reg_write(2'd1, 32'd8);
      send_words(1, "R9 word");
      watch_pulse(5, first, pulses);
      @(negedge clk); usb_in_avail = 1'b1;
      repeat (3) @(negedge clk);
      usb_in_avail = 1'b0;
      first = 0; pulses = 0; k = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk); #1;
         if (usb_addr != 2'd3) k++;
         if (usb_pktend) begin
            pulses++;
            if (first == 0) first = k;
         end
      end
      check("R9 pulse after inbound", first, 32'd9);
      check("R9 single pulse", pulses, 32'd1);
   endtask

   task automatic t_full;
      int first, pulses;
      reg_write(2'd1, 32'd4);
      send_words(128, "R11 full burst");
      watch_pulse(20, first, pulses);
      check("R11 no pulse after full packet", pulses, 32'd0);
      send_words(1, "R11 extra word");
      watch_pulse(10, first, pulses);
      check("R11 pulse for short packet", first, 32'd5);
   endtask

   task automatic t_zero;
      int first, pulses;
      reg_write(2'd1, 32'd0);
      send_words(2, "R10 words");
      watch_pulse(300, first, pulses);
      check("R10 disabled", pulses, 32'd0);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_ep();
      t_tx();
      t_rx();
      t_pktend();
      t_restart();
      t_inclear();
      t_full();
      t_zero();
      finish_run();
   end
endmodule